// File: doc/BRIEF.md
# Masked Vectored Interrupt Dispatcher

This block works next to a small processor's instruction sequencer and performs interrupt entry. At every instruction boundary the sequencer raises a strobe; the dispatcher then combines the interrupt enable mask with the pending status bits and, if any source is both enabled and pending, takes the lowest-numbered one. It tells the register file to clear the whole mask and the serviced status bit. It then spills the machine state to the memory stack and loads a new program counter from a small vector table near the top of memory.

The spill runs one memory write per cycle, moving downward from the current stack pointer. The old program counter goes first, then the flag byte, then general registers 0 to 6 in rising order. The stack pointer is written back with every push. After the last push the block reads the vector slot for the chosen source from a synchronous memory with one cycle of latency. It presents the result as the new program counter together with a one-cycle done pulse. The mask value from before the clear is kept on an output, so that a later return sequence can put it back.

Top module: `mvid_dispatch`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, mem_we_o, mem_re_o, sp_we_o and im_clr_o are 0 and saved_mask_o is 0.
- R2: An entry starts only on a clock edge where boundary_i is 1, the block is idle and (irq_mask_i & irq_stat_i) is nonzero. A zero mask, disjoint mask and status, or a low boundary_i start nothing, and no memory write occurs while busy_o is 0.
- R3: The serviced source is the lowest bit index set in (irq_mask_i & irq_stat_i), given on irq_num_o as a binary number.
- R4: In the cycle after acceptance, im_clr_o is 1 for one cycle and is_clr_o is one-hot with the serviced bit set (bit i = source i). saved_mask_o holds the mask value sampled at acceptance.
- R5: Nine memory writes follow in the cycles after acceptance, the first in cycle 2. Their addresses are SP-1 down to SP-9, where SP is sp_i at acceptance. The data, in order, is pc_i, flags_i, then register 0 through register 6 read through rf_addr_o/rf_data_i.
- R6: Each push cycle also pulses sp_we_o, with sp_wdata_o equal to that cycle's write address.
- R7: One cycle after the last write, mem_re_o is 1 for one cycle at address VEC_BASE (0xF8) plus the source number. Two cycles later done_o pulses for one cycle, with new_pc_o equal to the read data and busy_o back at 0.
- R8: A boundary strobe while an entry is in progress is ignored. In the first cycle after done_o the block can accept a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Sequencer is at an instruction boundary |
| irq_mask_i | input | NSRC | Interrupt enable mask register value |
| irq_stat_i | input | NSRC | Interrupt pending status register value |
| pc_i | input | AW | Program counter to save |
| flags_i | input | DW | Flag byte to save |
| sp_i | input | AW | Current stack pointer |
| rf_addr_o | output | RW | Register file read index |
| rf_data_i | input | DW | Register file read data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory write address |
| mem_wdata_o | output | DW | Memory write data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_raddr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Memory read data, one cycle after mem_re_o |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | AW | New stack pointer value |
| im_clr_o | output | 1 | Clear the whole mask register |
| is_clr_o | output | NSRC | Status bits to clear |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | Entry finished, new_pc_o valid |
| new_pc_o | output | AW | Program counter fetched from the vector table |
| irq_num_o | output | IW | Number of the serviced source |
| saved_mask_o | output | NSRC | Mask value before the clear |

## Verification
The selection is driven with all sources pending, a single top source, and mixed masks where the lowest pending bit differs from the lowest mask bit and the lowest status bit. These patterns separate a correct AND-then-lowest pick from a pick on only one operand or from a highest-first scan. Random stack pointers, register contents and vector bytes expose push-order, address-direction and vector-offset errors. Directed cases with a zero mask, disjoint operands and a held boundary strobe show that entries start only when they should and that the block accepts a new one right after done.

// File: rtl/mvid_pkg.sv
package mvid_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC,
    ST_WAIT,
    ST_LOAD
  } mvid_state_e;
endpackage

// File: rtl/mvid_prio.sv
module mvid_prio #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  // ripple from bit 0 upward: a bit wins only if no lower bit is set
  for (genvar g = 0; g < N; g++) begin : g_scan
    assign onehot_o[g] = pend_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | pend_i[g];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/mvid_push_sel.sv
module mvid_push_sel #(
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int NPUSH = 9,
  parameter int SW    = 4,
  parameter int RW    = 3
) (
  input  logic [SW-1:0] step_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] fl_i,
  input  logic [DW-1:0] gpr_i,
  output logic [RW-1:0] gpr_sel_o,
  output logic [DW-1:0] data_o
);
  localparam int FIXED = 2;  // program counter and flags precede registers

  assign gpr_sel_o = RW'(step_i - SW'(FIXED));

  always_comb begin
    if (step_i == '0)              data_o = DW'(pc_i);
    else if (step_i == SW'(1))     data_o = fl_i;
    else                           data_o = gpr_i;
  end
endmodule

// File: rtl/mvid_dispatch.sv
module mvid_dispatch #(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int NSRC     = 8,
  parameter int NGPR     = 7,
  parameter int VEC_BASE = 248,
  parameter int IW       = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int RW       = (NGPR > 1) ? $clog2(NGPR) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            boundary_i,
  input  logic [NSRC-1:0] irq_mask_i,
  input  logic [NSRC-1:0] irq_stat_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [DW-1:0]   flags_i,
  input  logic [AW-1:0]   sp_i,
  output logic [RW-1:0]   rf_addr_o,
  input  logic [DW-1:0]   rf_data_i,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_re_o,
  output logic [AW-1:0]   mem_raddr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            sp_we_o,
  output logic [AW-1:0]   sp_wdata_o,
  output logic            im_clr_o,
  output logic [NSRC-1:0] is_clr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   new_pc_o,
  output logic [IW-1:0]   irq_num_o,
  output logic [NSRC-1:0] saved_mask_o
);
  import mvid_pkg::*;

  localparam int NPUSH = NGPR + 2;
  localparam int SW    = $clog2(NPUSH + 1);

  mvid_state_e       state_q;
  logic [SW-1:0]     step_q;
  logic [AW-1:0]     sp_q;
  logic [AW-1:0]     pc_q;
  logic [DW-1:0]     fl_q;
  logic [IW-1:0]     num_q;

  logic              pend_any;
  logic [NSRC-1:0]   pend_onehot;
  logic [IW-1:0]     pend_idx;
  logic [DW-1:0]     push_data;
  logic [AW-1:0]     sp_next;

  mvid_prio #(.N(NSRC), .IW(IW)) u_prio (
    .pend_i   (irq_mask_i & irq_stat_i),
    .any_o    (pend_any),
    .onehot_o (pend_onehot),
    .idx_o    (pend_idx)
  );

  mvid_push_sel #(.DW(DW), .AW(AW), .NPUSH(NPUSH), .SW(SW), .RW(RW)) u_sel (
    .step_i    (step_q),
    .pc_i      (pc_q),
    .fl_i      (fl_q),
    .gpr_i     (rf_data_i),
    .gpr_sel_o (rf_addr_o),
    .data_o    (push_data)
  );

  assign sp_next   = sp_q - AW'(1);
  assign busy_o    = (state_q != ST_IDLE);
  assign irq_num_o = num_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      sp_q         <= '0;
      pc_q         <= '0;
      fl_q         <= '0;
      num_q        <= '0;
      saved_mask_o <= '0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
      mem_re_o     <= 1'b0;
      mem_raddr_o  <= '0;
      sp_we_o      <= 1'b0;
      sp_wdata_o   <= '0;
      im_clr_o     <= 1'b0;
      is_clr_o     <= '0;
      done_o       <= 1'b0;
      new_pc_o     <= '0;
    end else begin
      mem_we_o <= 1'b0;
      mem_re_o <= 1'b0;
      sp_we_o  <= 1'b0;
      im_clr_o <= 1'b0;
      is_clr_o <= '0;
      done_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (boundary_i && pend_any) begin
            state_q      <= ST_PUSH;
            step_q       <= '0;
            num_q        <= pend_idx;
            saved_mask_o <= irq_mask_i;
            pc_q         <= pc_i;
            fl_q         <= flags_i;
            sp_q         <= sp_i;
            im_clr_o     <= 1'b1;
            is_clr_o     <= pend_onehot;
          end
        end
        ST_PUSH: begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= sp_next;
          mem_wdata_o <= push_data;
          sp_we_o     <= 1'b1;
          sp_wdata_o  <= sp_next;
          sp_q        <= sp_next;
          if (step_q == SW'(NPUSH - 1)) state_q <= ST_VEC;
          else                          step_q  <= step_q + SW'(1);
        end
        ST_VEC: begin
          mem_re_o    <= 1'b1;
          mem_raddr_o <= AW'(VEC_BASE) + AW'(num_q);
          state_q     <= ST_WAIT;
        end
        ST_WAIT: state_q <= ST_LOAD;
        ST_LOAD: begin
          new_pc_o <= AW'(mem_rdata_i);
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mvid_dispatch_chk.sv
module mvid_dispatch_chk #(
  parameter int AW       = 8,
  parameter int NSRC     = 8,
  parameter int VEC_BASE = 248
) (
  input logic            clk,
  input logic            rst,
  input logic            boundary_i,
  input logic [NSRC-1:0] irq_mask_i,
  input logic [NSRC-1:0] irq_stat_i,
  input logic            busy_o,
  input logic            im_clr_o,
  input logic [NSRC-1:0] is_clr_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            sp_we_o,
  input logic [AW-1:0]   sp_wdata_o,
  input logic            mem_re_o,
  input logic [AW-1:0]   mem_raddr_o,
  input logic            done_o
);
  AST_START_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(boundary_i && ((irq_mask_i & irq_stat_i) != '0))); // R2
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_we_o); // R2
  AST_CLR_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(is_clr_o)); // R3
  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (im_clr_o && $countones(is_clr_o) == 1)); // R4
  AST_WRITE_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == AW'($past(mem_addr_o) - AW'(1)))); // R5
  AST_SP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (sp_we_o && sp_wdata_o == mem_addr_o)); // R6
  AST_READ_NOT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(mem_re_o && mem_we_o)); // R7
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    mem_re_o |-> (AW'(mem_raddr_o - AW'(VEC_BASE)) < AW'(NSRC))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R7
endmodule

bind mvid_dispatch mvid_dispatch_chk #(.AW(AW), .NSRC(NSRC), .VEC_BASE(VEC_BASE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .boundary_i (boundary_i),
  .irq_mask_i (irq_mask_i),
  .irq_stat_i (irq_stat_i),
  .busy_o     (busy_o),
  .im_clr_o   (im_clr_o),
  .is_clr_o   (is_clr_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .sp_we_o    (sp_we_o),
  .sp_wdata_o (sp_wdata_o),
  .mem_re_o   (mem_re_o),
  .mem_raddr_o(mem_raddr_o),
  .done_o     (done_o)
);

// File: tb/mvid_dispatch_tb_top.sv
module mvid_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       boundary = 1'b0;
  logic [7:0] mask = '0, stat = '0, pc = '0, flags = '0, sp = '0;
  logic [2:0] rf_addr;
  logic [7:0] rf_data;
  logic       mem_we, mem_re, sp_we, im_clr, busy, done;
  logic [7:0] mem_addr, mem_wdata, mem_raddr, sp_wdata, new_pc, is_clr, saved_mask;
  logic [7:0] mem_rdata = '0;
  logic [2:0] irq_num;
  logic [7:0] gpr [8];
  logic [7:0] mem [256];

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_data = gpr[rf_addr];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_raddr];
  end

  mvid_dispatch dut_i (
    .clk(clk), .rst(rst), .boundary_i(boundary), .irq_mask_i(mask), .irq_stat_i(stat),
    .pc_i(pc), .flags_i(flags), .sp_i(sp), .rf_addr_o(rf_addr), .rf_data_i(rf_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_re_o(mem_re), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .sp_we_o(sp_we), .sp_wdata_o(sp_wdata), .im_clr_o(im_clr), .is_clr_o(is_clr),
    .busy_o(busy), .done_o(done), .new_pc_o(new_pc), .irq_num_o(irq_num),
    .saved_mask_o(saved_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 0;
  endfunction

  // one full entry; with hold the strobe stays high to test R8
  task automatic run_entry(input logic [7:0] m, input logic [7:0] s, input logic [7:0] p,
                           input logic [7:0] f, input logic [7:0] sptr, input bit hold);
    logic [7:0] exp_data [9];
    int en;
    @(negedge clk);
    mask = m; stat = s; pc = p; flags = f; sp = sptr; boundary = 1'b1;
    en = lowest(m & s);
    exp_data[0] = p;
    exp_data[1] = f;
    for (int i = 0; i < 7; i++) exp_data[2+i] = gpr[i];
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (!hold) boundary = 1'b0;
        chk(irq_num == 3'(en), "R3 irq number", irq_num, en);
        chk(im_clr && is_clr == 8'(1 << en), "R4 clear pulses", {im_clr, is_clr}, {1'b1, 8'(1 << en)});
        chk(saved_mask == m, "R4 saved mask", saved_mask, m);
      end else if (k <= 10) begin
        chk(mem_we && mem_addr == 8'(sptr - 8'(k - 1)) && mem_wdata == exp_data[k-2],
            "R5 push", {mem_we, mem_addr, mem_wdata}, {1'b1, 8'(sptr - 8'(k - 1)), exp_data[k-2]});
        chk(sp_we && sp_wdata == 8'(sptr - 8'(k - 1)), "R6 sp write", {sp_we, sp_wdata},
            {1'b1, 8'(sptr - 8'(k - 1))});
        if (hold) chk(!im_clr, "R8 strobe ignored while busy", im_clr, 0);
      end else if (k == 11) begin
        chk(mem_re && !mem_we && mem_raddr == 8'(8'hF8 + en), "R7 vector read",
            {mem_re, mem_raddr}, {1'b1, 8'(8'hF8 + en)});
      end else if (k == 12) begin
        chk(!done && busy, "R7 done not early", {done, busy}, 2'b01);
      end else begin
        chk(done && !busy && new_pc == mem[8'hF8 + en], "R7 done and new pc",
            {done, busy, new_pc}, {2'b10, mem[8'hF8 + en]});
      end
    end
    if (hold) begin
      @(negedge clk);
      boundary = 1'b0;
      chk(im_clr && busy, "R8 re-accept after done", {im_clr, busy}, 2'b11);
      repeat (13) @(negedge clk);
      chk(!busy, "R8 second entry ends", busy, 0);
    end
  endtask

  task automatic no_entry(input logic [7:0] m, input logic [7:0] s, input bit b, input string msg);
    @(negedge clk);
    mask = m; stat = s; boundary = b;
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !mem_we && !im_clr, msg, {busy, mem_we, im_clr}, 0);
    end
    boundary = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] m, s;
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 8; i++) gpr[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re && !sp_we && !im_clr && saved_mask == 0,
        "R1 reset state", {busy, done, mem_we, mem_re, sp_we, im_clr, saved_mask}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1 after reset", {busy, done}, 0);

    no_entry(8'h00, 8'hFF, 1'b1, "R2 zero mask");
    no_entry(8'h0F, 8'hF0, 1'b1, "R2 disjoint mask and status");
    no_entry(8'hFF, 8'hFF, 1'b0, "R2 no boundary");

    run_entry(8'hFF, 8'hFF, 8'h12, 8'h01, 8'hC0, 1'b0);   // source 0
    run_entry(8'h80, 8'h80, 8'h34, 8'h04, 8'h40, 1'b0);   // source 7, top slot
    run_entry(8'h0A, 8'h0C, 8'h56, 8'h02, 8'h30, 1'b0);   // R3: and gives bit 3
    run_entry(8'h60, 8'hFF, 8'h78, 8'h00, 8'h20, 1'b1);   // R8 held strobe

    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 8; i++) gpr[i] = 8'($urandom);
      m = 8'($urandom);
      s = 8'($urandom);
      if ((m & s) == 8'h00) begin m[7] = 1'b1; s[7] = 1'b1; end
      run_entry(m, s, 8'($urandom), 8'($urandom), 8'(8'h20 + ($urandom % 8'hC0)), 1'b0);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule